// File: doc/BRIEF.md
# Write-Once Coherence Directory Controller

This block is the system-side coherence logic for a processor whose first-level cache sits behind a private second-level cache. Other caching masters share a separate bus. The block keeps a direct-mapped tag and state directory that mirrors the second-level cache. It watches the processor's line fills and writes, and for each one it drives a write-back/write-through select to each cache level. The two selects are chosen so that the first write to a shared line is written through to memory and the other masters are told to invalidate their copies. After that write the second-level copy becomes the exclusive owner, while the first-level copy stays shared.

Other masters run inquire cycles against the directory. The block answers each inquire in the same cycle with a hit flag and a hit-on-modified flag. A modified line is never given up silently: the block first requests a write-back of the line and waits for the acknowledge, and only then lowers the line to shared or invalid. While it waits, the block raises a stall and ignores every strobe. An inquire that arrives together with a processor request takes precedence, and the processor request is dropped.

Top module: `wonce_coh_ctrl`

## Requirements
- R1: After reset every directory entry is invalid, so an inquire to any line address reports no hit.
- R2: A processor fill drives both selects low (write-through) in the strobe cycle. A missing line is installed in the shared state; a fill that hits leaves the entry unchanged.
- R3: A processor write that hits a shared line drives the second-level select high, raises the memory write-through flag and the invalidate request in the same cycle, and moves the line to exclusive.
- R4: A processor write that hits an exclusive or modified line drives the second-level select high with no memory write and no invalidate request, and leaves the line modified.
- R5: A processor write that misses drives both selects low, raises the memory write-through flag, leaves the invalidate request low and allocates nothing.
- R6: An inquire raises the hit flag in its strobe cycle when the line is valid with a matching tag. It also raises the hit-on-modified flag when that line is modified.
- R7: An inquire hitting an exclusive or shared line takes effect at the next clock edge, with no write-back. A reading inquire leaves the line shared; an invalidating inquire (invalidate flag = 1) makes it invalid.
- R8: An inquire hitting a modified line raises the write-back request in the following cycle, with the write-back address equal to the inquired line address {tag, index}. The request holds until the acknowledge. At the acknowledged edge the line becomes shared (reading inquire) or invalid (invalidating inquire).
- R9: A fill whose index holds a modified line with a different tag requests a write-back of the old line address first. After the acknowledge the new tag is installed in the shared state.
- R10: When an inquire and a processor request arrive in the same cycle, the inquire is served. The processor request changes no state and drives no select, memory or invalidate output, and the stall output is high.
- R11: While a write-back is awaited, the stall output is high, the hit flags, selects, memory write and invalidate outputs stay low, and all strobes are ignored.
- R12: The first-level select is low (write-through) for every fill and write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuFill | input | 1 | Processor line fill strobe (read miss) |
| cpuWrite | input | 1 | Processor write strobe |
| cpuAddr | input | TAG_W+IDX_W | Processor line address {tag, index} |
| snpValid | input | 1 | Inquire strobe from another master |
| snpInval | input | 1 | Inquire asks for invalidation (1) or a read (0) |
| snpAddr | input | TAG_W+IDX_W | Inquire line address {tag, index} |
| wbAck | input | 1 | Write-back done acknowledge |
| l1WbSel | output | 1 | First-level select, 1 = write-back, 0 = write-through |
| l2WbSel | output | 1 | Second-level select, 1 = write-back, 0 = write-through |
| memWrite | output | 1 | Current processor write goes through to memory |
| invReq | output | 1 | Invalidate request to the other-master bus |
| snpHit | output | 1 | Inquire hit a valid line |
| snpHitMod | output | 1 | Inquire hit a modified line |
| wbReq | output | 1 | Write-back request |
| wbAddr | output | TAG_W+IDX_W | Line address to write back |
| cpuStall | output | 1 | Processor request not taken this cycle |

## Verification
The selects, memory and invalidate flags, hit flags and stall are combinational on the strobe, so each is due in the strobe cycle itself. The bench drives inputs on the falling edge and samples these outputs two nanoseconds later, before the rising edge that commits the state. A directory state change shows up only through a later strobe, one rising edge after the one that caused it, and the write-back request is due one edge after the inquire or fill that needed it. The bench's reference model commits its own state at that same edge, once the comparison for the cycle is done, so every expected value refers to the state that the RTL holds in that cycle.

// File: rtl/wonce_pkg.sv
package wonce_pkg;

  typedef enum logic [1:0] {
    LS_INV = 2'd0,
    LS_SHR = 2'd1,
    LS_EXC = 2'd2,
    LS_MOD = 2'd3
  } lineSt_t;

  typedef enum logic [1:0] {
    PK_SNPRD  = 2'd0,
    PK_SNPINV = 2'd1,
    PK_FILL   = 2'd2
  } pendKind_t;

  typedef enum logic {
    CS_IDLE   = 1'b0,
    CS_WBWAIT = 1'b1
  } ctlSt_t;

  // directory update strobes from control to datapath
  typedef struct packed {
    logic    stWe;
    logic    tagWe;
    lineSt_t st;
  } dirUpd_t;

endpackage

// File: rtl/wonce_dir_dp.sv
module wonce_dir_dp
  import wonce_pkg::*;
#(
  parameter int TAG_W = 8,
  parameter int IDX_W = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [TAG_W+IDX_W-1:0] cpuAddr,
  input  logic [TAG_W+IDX_W-1:0] snpAddr,
  input  dirUpd_t                upd,
  input  logic [IDX_W-1:0]       updIdx,
  input  logic [TAG_W-1:0]       updTag,
  output logic                   cpuHit,
  output lineSt_t                cpuSt,
  output logic [TAG_W-1:0]       cpuOldTag,
  output logic                   snpHitRaw,
  output lineSt_t                snpSt
);

  localparam int ENTRIES = 1 << IDX_W;

  lineSt_t          stMem  [ENTRIES];
  logic [TAG_W-1:0] tagMem [ENTRIES];

  logic [IDX_W-1:0] cpuIdx, snpIdx;
  logic [TAG_W-1:0] cpuTag, snpTag;

  assign cpuIdx = cpuAddr[IDX_W-1:0];
  assign cpuTag = cpuAddr[TAG_W+IDX_W-1:IDX_W];
  assign snpIdx = snpAddr[IDX_W-1:0];
  assign snpTag = snpAddr[TAG_W+IDX_W-1:IDX_W];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < ENTRIES; i++) stMem[i] <= LS_INV;
    end else if (upd.stWe) begin
      stMem[updIdx] <= upd.st;
    end
  end

  always_ff @(posedge clk) begin
    if (upd.tagWe) tagMem[updIdx] <= updTag;
  end

  always_comb begin
    cpuSt     = stMem[cpuIdx];
    cpuOldTag = tagMem[cpuIdx];
    cpuHit    = (cpuSt != LS_INV) && (cpuOldTag == cpuTag);
    snpSt     = stMem[snpIdx];
    snpHitRaw = (snpSt != LS_INV) && (tagMem[snpIdx] == snpTag);
  end

endmodule

// File: rtl/wonce_ctl.sv
module wonce_ctl
  import wonce_pkg::*;
#(
  parameter int TAG_W = 8,
  parameter int IDX_W = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   cpuFill,
  input  logic                   cpuWrite,
  input  logic [TAG_W+IDX_W-1:0] cpuAddr,
  input  logic                   snpValid,
  input  logic                   snpInval,
  input  logic [TAG_W+IDX_W-1:0] snpAddr,
  input  logic                   wbAck,
  input  logic                   cpuHit,
  input  lineSt_t                cpuSt,
  input  logic [TAG_W-1:0]       cpuOldTag,
  input  logic                   snpHitRaw,
  input  lineSt_t                snpSt,
  output dirUpd_t                upd,
  output logic [IDX_W-1:0]       updIdx,
  output logic [TAG_W-1:0]       updTag,
  output logic                   l1WbSel,
  output logic                   l2WbSel,
  output logic                   memWrite,
  output logic                   invReq,
  output logic                   snpHit,
  output logic                   snpHitMod,
  output logic                   wbReq,
  output logic [TAG_W+IDX_W-1:0] wbAddr,
  output logic                   cpuStall
);

  localparam int ADDR_W = TAG_W + IDX_W;

  ctlSt_t           ctlState;
  pendKind_t        pendKind;
  logic [IDX_W-1:0] pendIdx;
  logic [TAG_W-1:0] pendTag;
  logic [ADDR_W-1:0] wbAddrQ;

  logic             capWait;
  pendKind_t        capKind;
  logic [ADDR_W-1:0] capWbAddr;

  logic [IDX_W-1:0] cpuIdx, snpIdx;
  logic [TAG_W-1:0] cpuTag;

  assign cpuIdx = cpuAddr[IDX_W-1:0];
  assign cpuTag = cpuAddr[ADDR_W-1:IDX_W];
  assign snpIdx = snpAddr[IDX_W-1:0];

  always_comb begin
    upd       = '0;
    updIdx    = cpuIdx;
    updTag    = cpuTag;
    l1WbSel   = 1'b0;
    l2WbSel   = 1'b0;
    memWrite  = 1'b0;
    invReq    = 1'b0;
    snpHit    = 1'b0;
    snpHitMod = 1'b0;
    wbReq     = 1'b0;
    cpuStall  = 1'b0;
    capWait   = 1'b0;
    capKind   = PK_SNPRD;
    capWbAddr = snpAddr;

    if (ctlState == CS_WBWAIT) begin
      wbReq    = 1'b1;
      cpuStall = 1'b1;
      if (wbAck) begin
        upd.stWe = 1'b1;
        updIdx   = pendIdx;
        updTag   = pendTag;
        unique case (pendKind)
          PK_SNPRD:  upd.st = LS_SHR;
          PK_SNPINV: upd.st = LS_INV;
          default: begin
            upd.st    = LS_SHR;
            upd.tagWe = 1'b1;
          end
        endcase
      end
    end else if (snpValid) begin
      cpuStall  = 1'b1;
      snpHit    = snpHitRaw;
      snpHitMod = snpHitRaw && (snpSt == LS_MOD);
      updIdx    = snpIdx;
      if (snpHitRaw) begin
        if (snpSt == LS_MOD) begin
          capWait   = 1'b1;
          capKind   = snpInval ? PK_SNPINV : PK_SNPRD;
          capWbAddr = snpAddr;
        end else if (snpInval) begin
          upd.stWe = 1'b1;
          upd.st   = LS_INV;
        end else if (snpSt == LS_EXC) begin
          upd.stWe = 1'b1;
          upd.st   = LS_SHR;
        end
      end
    end else if (cpuFill) begin
      if (!cpuHit) begin
        if (cpuSt == LS_MOD) begin
          capWait   = 1'b1;
          capKind   = PK_FILL;
          capWbAddr = {cpuOldTag, cpuIdx};
        end else begin
          upd.stWe  = 1'b1;
          upd.tagWe = 1'b1;
          upd.st    = LS_SHR;
        end
      end
    end else if (cpuWrite) begin
      if (cpuHit) begin
        l2WbSel  = 1'b1;
        upd.stWe = 1'b1;
        if (cpuSt == LS_SHR) begin
          memWrite = 1'b1;
          invReq   = 1'b1;
          upd.st   = LS_EXC;
        end else begin
          upd.st   = LS_MOD;
        end
      end else begin
        memWrite = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctlState <= CS_IDLE;
      pendKind <= PK_SNPRD;
      pendIdx  <= '0;
      pendTag  <= '0;
      wbAddrQ  <= '0;
    end else if (ctlState == CS_WBWAIT) begin
      if (wbAck) ctlState <= CS_IDLE;
    end else if (capWait) begin
      ctlState <= CS_WBWAIT;
      pendKind <= capKind;
      pendIdx  <= capWbAddr[IDX_W-1:0];
      pendTag  <= (capKind == PK_FILL) ? cpuTag : capWbAddr[ADDR_W-1:IDX_W];
      wbAddrQ  <= capWbAddr;
    end
  end

  assign wbAddr = wbAddrQ;

  // R8: request and address held until acknowledged
  a_r8_wb_hold: assert property (@(posedge clk) disable iff (!rstN)
    (wbReq && !wbAck) |=> (wbReq && $stable(wbAddr)));

  // R8: acknowledge releases the request
  a_r8_wb_release: assert property (@(posedge clk) disable iff (!rstN)
    (wbReq && wbAck) |=> !wbReq);

  // R11: quiet outputs while waiting
  a_r11_quiet_wait: assert property (@(posedge clk) disable iff (!rstN)
    wbReq |-> (cpuStall && !snpHit && !l2WbSel && !memWrite && !invReq));

  // R6: modified hit is a hit
  a_r6_mod_is_hit: assert property (@(posedge clk) disable iff (!rstN)
    snpHitMod |-> snpHit);

  // R3: invalidate only with a write going through to memory
  a_r3_inv_with_write: assert property (@(posedge clk) disable iff (!rstN)
    invReq |-> (cpuWrite && memWrite && l2WbSel));

  // R10: inquire wins over the processor
  a_r10_snoop_first: assert property (@(posedge clk) disable iff (!rstN)
    snpValid |-> (cpuStall && !memWrite && !l2WbSel && !invReq));

  // R2: fills are written through at both levels
  a_r2_fill_wt: assert property (@(posedge clk) disable iff (!rstN)
    (cpuFill && !cpuStall) |-> (!l1WbSel && !l2WbSel && !memWrite));

endmodule

// File: rtl/wonce_coh_ctrl.sv
module wonce_coh_ctrl
  import wonce_pkg::*;
#(
  parameter int TAG_W = 8,
  parameter int IDX_W = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   cpuFill,
  input  logic                   cpuWrite,
  input  logic [TAG_W+IDX_W-1:0] cpuAddr,
  input  logic                   snpValid,
  input  logic                   snpInval,
  input  logic [TAG_W+IDX_W-1:0] snpAddr,
  input  logic                   wbAck,
  output logic                   l1WbSel,
  output logic                   l2WbSel,
  output logic                   memWrite,
  output logic                   invReq,
  output logic                   snpHit,
  output logic                   snpHitMod,
  output logic                   wbReq,
  output logic [TAG_W+IDX_W-1:0] wbAddr,
  output logic                   cpuStall
);

  dirUpd_t          upd;
  logic [IDX_W-1:0] updIdx;
  logic [TAG_W-1:0] updTag;
  logic             cpuHit, snpHitRaw;
  lineSt_t          cpuSt, snpSt;
  logic [TAG_W-1:0] cpuOldTag;

  wonce_dir_dp #(.TAG_W(TAG_W), .IDX_W(IDX_W)) u_dp (
    .clk(clk), .rstN(rstN),
    .cpuAddr(cpuAddr), .snpAddr(snpAddr),
    .upd(upd), .updIdx(updIdx), .updTag(updTag),
    .cpuHit(cpuHit), .cpuSt(cpuSt), .cpuOldTag(cpuOldTag),
    .snpHitRaw(snpHitRaw), .snpSt(snpSt)
  );

  wonce_ctl #(.TAG_W(TAG_W), .IDX_W(IDX_W)) u_ctl (
    .clk(clk), .rstN(rstN),
    .cpuFill(cpuFill), .cpuWrite(cpuWrite), .cpuAddr(cpuAddr),
    .snpValid(snpValid), .snpInval(snpInval), .snpAddr(snpAddr),
    .wbAck(wbAck),
    .cpuHit(cpuHit), .cpuSt(cpuSt), .cpuOldTag(cpuOldTag),
    .snpHitRaw(snpHitRaw), .snpSt(snpSt),
    .upd(upd), .updIdx(updIdx), .updTag(updTag),
    .l1WbSel(l1WbSel), .l2WbSel(l2WbSel), .memWrite(memWrite),
    .invReq(invReq), .snpHit(snpHit), .snpHitMod(snpHitMod),
    .wbReq(wbReq), .wbAddr(wbAddr), .cpuStall(cpuStall)
  );

endmodule

// File: tb/wonce_coh_ctrl_bench.sv
`timescale 1ns/1ps
module wonce_coh_ctrl_bench;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cpuFill = 0, cpuWrite = 0, snpValid = 0, snpInval = 0, wbAck = 0;
  logic [11:0] cpuAddr = '0, snpAddr = '0;
  logic l1WbSel, l2WbSel, memWrite, invReq, snpHit, snpHitMod, wbReq, cpuStall;
  logic [11:0] wbAddr;

  int checks = 0;
  int fails = 0;

  // reference directory: state 0 I, 1 S, 2 E, 3 M
  int mTag [16];
  int mSt  [16];
  bit mWait = 0;
  int mKind = 0;
  int mIdx = 0;
  int mNewTag = 0;
  logic [11:0] mWbAddr = '0;

  always #4 clk = ~clk;

  wonce_coh_ctrl #(.TAG_W(8), .IDX_W(4)) u_wonce_coh_ctrl (
    .clk(clk), .rstN(rstN),
    .cpuFill(cpuFill), .cpuWrite(cpuWrite), .cpuAddr(cpuAddr),
    .snpValid(snpValid), .snpInval(snpInval), .snpAddr(snpAddr),
    .wbAck(wbAck),
    .l1WbSel(l1WbSel), .l2WbSel(l2WbSel), .memWrite(memWrite),
    .invReq(invReq), .snpHit(snpHit), .snpHitMod(snpHitMod),
    .wbReq(wbReq), .wbAddr(wbAddr), .cpuStall(cpuStall)
  );

  task automatic step(input bit f, input bit w, input logic [11:0] ca,
                      input bit s, input bit si, input logic [11:0] sa,
                      input bit ack, input string tag);
    bit eL2 = 0, eMem = 0, eInv = 0, eHit = 0, eHm = 0, eWb = 0, eStall = 0;
    logic [7:0] expV, gotV;
    logic [11:0] expWb = '0;
    string req = "R2";
    int ci, ct, sx, stg;
    bit hit;
    @(negedge clk);
    cpuFill = f; cpuWrite = w; cpuAddr = ca;
    snpValid = s; snpInval = si; snpAddr = sa; wbAck = ack;
    #2;
    ci = int'(ca[3:0]); ct = int'(ca[11:4]);
    sx = int'(sa[3:0]); stg = int'(sa[11:4]);
    if (mWait) begin
      eWb = 1; eStall = 1; expWb = mWbAddr; req = "R11";
      if (ack) begin
        req = "R8";
        if (mKind == 0) mSt[mIdx] = 1;
        else if (mKind == 1) mSt[mIdx] = 0;
        else begin mSt[mIdx] = 1; mTag[mIdx] = mNewTag; req = "R9"; end
        mWait = 0;
      end
    end else if (s) begin
      eStall = 1;
      req = (f || w) ? "R10" : "R6";
      hit = (mSt[sx] != 0) && (mTag[sx] == stg);
      eHit = hit; eHm = hit && (mSt[sx] == 3);
      if (hit) begin
        if (mSt[sx] == 3) begin
          mWait = 1; mKind = si ? 1 : 0; mIdx = sx; mWbAddr = sa;
        end else if (si) mSt[sx] = 0;
        else mSt[sx] = 1;
      end
    end else if (f) begin
      req = "R2";
      hit = (mSt[ci] != 0) && (mTag[ci] == ct);
      if (!hit) begin
        if (mSt[ci] == 3) begin
          mWait = 1; mKind = 2; mIdx = ci; mNewTag = ct;
          mWbAddr = {mTag[ci][7:0], ci[3:0]}; req = "R9";
        end else begin
          mSt[ci] = 1; mTag[ci] = ct;
        end
      end
    end else if (w) begin
      hit = (mSt[ci] != 0) && (mTag[ci] == ct);
      if (hit && mSt[ci] == 1) begin
        eL2 = 1; eMem = 1; eInv = 1; mSt[ci] = 2; req = "R3";
      end else if (hit) begin
        eL2 = 1; mSt[ci] = 3; req = "R4";
      end else begin
        eMem = 1; req = "R5";
      end
    end
    if (tag != "") req = tag;
    gotV = {l1WbSel, l2WbSel, memWrite, invReq, snpHit, snpHitMod, wbReq, cpuStall};
    expV = {1'b0, eL2, eMem, eInv, eHit, eHm, eWb, eStall};
    if (gotV[7]) req = "R12";
    checks++;
    if (gotV !== expV) begin
      fails++;
      $display("FAIL %s outputs got %b expected %b", req, gotV, expV);
    end
    if (eWb) begin
      checks++;
      if (wbAddr !== expWb) begin
        fails++;
        $display("FAIL %s wbAddr got %h expected %h", req, wbAddr, expWb);
      end
    end
  endtask

  task automatic idle();
    step(0, 0, '0, 0, 0, '0, 0, "");
  endtask

  initial begin
    #1200000;
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [11:0] a, b;
    void'($urandom(32'd4321));
    for (int i = 0; i < 16; i++) begin mSt[i] = 0; mTag[i] = 0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: every index misses after reset
    for (int i = 0; i < 16; i++) step(0, 0, '0, 1, 0, {8'h00, i[3:0]}, 0, "R1");

    a = 12'h012; b = 12'h022;
    step(1, 0, a, 0, 0, '0, 0, "R2");     // fill -> S
    step(0, 0, '0, 1, 0, a, 0, "R6");     // read inquire hits S
    step(0, 1, a, 0, 0, '0, 0, "R3");     // first write -> E
    step(0, 1, a, 0, 0, '0, 0, "R4");     // second write -> M
    step(0, 1, a, 0, 0, '0, 0, "R4");     // M stays M
    step(0, 0, '0, 1, 0, a, 0, "R8");     // read inquire hits M
    step(0, 1, a, 1, 1, a, 0, "R11");     // strobes ignored while waiting
    step(1, 0, b, 0, 0, '0, 0, "R11");
    step(0, 0, '0, 0, 0, '0, 1, "R8");    // acknowledge -> S
    step(0, 0, '0, 1, 1, a, 0, "R7");     // invalidating inquire on S -> I
    step(0, 1, a, 0, 0, '0, 0, "R5");     // write miss, no allocate
    step(0, 0, '0, 1, 0, a, 0, "R5");     // still a miss
    step(1, 0, a, 0, 0, '0, 0, "R2");
    step(0, 1, a, 0, 0, '0, 0, "R3");     // -> E
    step(0, 0, '0, 1, 0, a, 0, "R7");     // E -> S at once
    step(0, 1, a, 0, 0, '0, 0, "R3");     // S again, write-through again
    step(0, 0, '0, 1, 1, a, 0, "R7");     // E -> I at once
    step(0, 0, '0, 1, 0, a, 0, "R7");
    step(1, 0, a, 0, 0, '0, 0, "R2");
    step(0, 1, a, 0, 0, '0, 0, "R3");
    step(0, 1, a, 0, 0, '0, 0, "R4");     // M
    step(1, 0, b, 0, 0, '0, 0, "R9");     // evict modified a
    idle();
    step(0, 0, '0, 0, 0, '0, 1, "R9");
    step(0, 0, '0, 1, 0, b, 0, "R9");     // b installed shared
    step(0, 0, '0, 1, 0, a, 0, "R9");     // a gone
    step(0, 1, b, 1, 0, b, 0, "R10");     // inquire and write together
    step(0, 1, b, 0, 0, '0, 0, "R10");    // b still shared: first write
    step(1, 0, a, 1, 1, b, 0, "R10");     // fill dropped under inquire
    step(0, 0, '0, 1, 0, a, 0, "R10");    // a not installed

    for (int n = 0; n < 4000; n++) begin
      int op;
      logic [11:0] ra, rs;
      ra = {8'($urandom % 3), 4'($urandom % 4)};
      rs = {8'($urandom % 3), 4'($urandom % 4)};
      op = int'($urandom % 10);
      if (mWait) begin
        step(op < 3, op == 3, ra, op > 6, op[0], rs, ($urandom % 4) == 0, "");
      end else begin
        unique case (op)
          0, 1, 2: step(1, 0, ra, 0, 0, rs, 0, "");
          3, 4, 5: step(0, 1, ra, 0, 0, rs, 0, "");
          6, 7, 8: step(0, 0, ra, 1, ($urandom % 2) == 1, rs, 0, "");
          default: step(($urandom % 2) == 1, 1, ra, 1, ($urandom % 2) == 1, rs, 0, "");
        endcase
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule